// File: doc/BRIEF.md
# Banked Memory Address Decoder

This block sits between a CPU's 8-bit data port and a set of small on-block memories. It turns every 16-bit CPU address into a one-hot region select and a local offset within that region, using an irregular fixed map. Reads return the selected region's data one clock later. Writes go only to the region that was decoded. Addresses that fall in no region read back as all ones, and writes to them change nothing.

The map holds ten regions: a fixed ROM window, a banked ROM window, video RAM, external RAM, a fixed and a banked work-RAM window, an object-attribute area, an I/O page, high RAM and a single interrupt-enable byte. Two bank-number inputs choose the storage behind the two banked windows. A ROM bank number of zero is promoted to one. Each region keeps only a small store of `2**STORE_AW` bytes per bank, so addresses inside a region mirror onto it.

Top module: `mem_map_decoder`

## Requirements
- R1: `region_sel` is decoded combinationally from `cpu_addr` with this bit assignment and these ranges:
  - bit0: 0x0000–0x3FFF
  - bit1: 0x4000–0x7FFF
  - bit2: 0x8000–0x9FFF
  - bit3: 0xA000–0xBFFF
  - bit4: 0xC000–0xCFFF
  - bit5: 0xD000–0xDFFF
  - bit6: 0xFE00–0xFE9F
  - bit7: 0xFF00–0xFF7F
  - bit8: 0xFF80–0xFFFE
  - bit9: 0xFFFF

  Every other address (0xE000–0xFDFF and 0xFEA0–0xFEFF) sets no bit.
- R2: `region_off` equals `cpu_addr` minus the first address of the selected region. It is 0 when no region is selected.
- R3: At most one bit of `region_sel` is set at any time.
- R4: A read of an address that selects no region returns 0xFF.
- R5: A write to an address that selects no region changes no stored byte.
- R6: When `cpu_rd` is high at a rising edge, `rdata`, `rd_sel_q` (the select captured with the address) and `rd_valid` are updated at that edge. When `cpu_rd` is low, `rd_valid` goes low and `rdata` and `rd_sel_q` hold their values.
- R7: The banked ROM window (bit1) stores into and reads from bank `rom_bank`. A `rom_bank` value of 0 accesses bank 1.
- R8: The banked work-RAM window (bit5) stores into and reads from bank `wram_bank`, with bank 0 being a distinct bank.
- R9: While `rst_n` is low at a rising edge, `rdata`, `rd_sel_q` and `rd_valid` are cleared to 0 at that edge.
- R10: Within a region, the stored byte is chosen by the low `STORE_AW` bits of `region_off` (with the bank number above them for bit1 and bit5). The interrupt-enable region holds one byte. A read returns the last byte written to the same region, bank and index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | DW | Write data |
| rom_bank | input | ROMB_W | Bank number for the banked ROM window |
| wram_bank | input | WRAMB_W | Bank number for the banked work-RAM window |
| region_sel | output | 10 | One-hot region select, combinational |
| region_off | output | 16 | Local offset in the selected region, combinational |
| rd_valid | output | 1 | Read data valid, registered |
| rd_sel_q | output | 10 | Region select captured with the read |
| rdata | output | DW | Registered read data |

## Verification
On every cycle, the assertions check four things:
- the select is one-hot or empty;
- the fixed ROM and banked ROM windows decode with the right offset;
- a read captures the select of the previous cycle, and an idle cycle holds the read outputs;
- an unmapped read shows 0xFF.

Other behaviour shows only through the bench's stored-data scenarios. These cover mirroring onto each region's small store, the promotion of ROM bank 0 to bank 1, separate work-RAM banks, and the absence of any effect from writes into the holes. The bench shows these by sweeping the whole address space with writes and then with reads against an arithmetic model.

// File: rtl/mmd_pkg.sv
// Package: shared constants of the banked memory address decoder.
// Assumes a 16-bit address space and ten regions in fixed select order.
package mmd_pkg;
    localparam int NREG     = 10;
    localparam int RG_ROM0  = 0;
    localparam int RG_ROMX  = 1;
    localparam int RG_VRAM  = 2;
    localparam int RG_XRAM  = 3;
    localparam int RG_WRAM0 = 4;
    localparam int RG_WRAMX = 5;
    localparam int RG_OAM   = 6;
    localparam int RG_IO    = 7;
    localparam int RG_HRAM  = 8;
    localparam int RG_IE    = 9;

    // First address of each region
    function automatic logic [15:0] region_base(input int r);
        case (r)
            RG_ROM0:  return 16'h0000;
            RG_ROMX:  return 16'h4000;
            RG_VRAM:  return 16'h8000;
            RG_XRAM:  return 16'hA000;
            RG_WRAM0: return 16'hC000;
            RG_WRAMX: return 16'hD000;
            RG_OAM:   return 16'hFE00;
            RG_IO:    return 16'hFF00;
            RG_HRAM:  return 16'hFF80;
            default:  return 16'hFFFF;
        endcase
    endfunction
endpackage

// File: rtl/mmd_region_decode.sv
// Module: combinational region decoder.
// Maps a 16-bit address to a one-hot select and a region-local offset.
// Assumes the region order of mmd_pkg; holes give an empty select and offset 0.
module mmd_region_decode
    import mmd_pkg::*;
(
    input  logic [15:0]     addr,
    output logic [NREG-1:0] sel,
    output logic [15:0]     off
);
    logic [15:0] base;

    // Pick the region from the upper address bits
    always_comb begin
        sel = '0;
        if (addr[15:14] == 2'b00)                        sel[RG_ROM0]  = 1'b1;
        else if (addr[15:14] == 2'b01)                   sel[RG_ROMX]  = 1'b1;
        else if (addr[15:13] == 3'b100)                  sel[RG_VRAM]  = 1'b1;
        else if (addr[15:13] == 3'b101)                  sel[RG_XRAM]  = 1'b1;
        else if (addr[15:12] == 4'hC)                    sel[RG_WRAM0] = 1'b1;
        else if (addr[15:12] == 4'hD)                    sel[RG_WRAMX] = 1'b1;
        else if (addr[15:8] == 8'hFE && addr[7:0] < 8'hA0) sel[RG_OAM] = 1'b1;
        else if (addr[15:7] == 9'h1FE)                   sel[RG_IO]    = 1'b1;
        else if (addr == 16'hFFFF)                       sel[RG_IE]    = 1'b1;
        else if (addr[15:7] == 9'h1FF)                   sel[RG_HRAM]  = 1'b1;
    end

    // Subtract the base of the selected region
    always_comb begin
        base = 16'h0000;
        for (int r = 0; r < NREG; r++) begin
            if (sel[r]) base = region_base(r);
        end
        off = (sel == '0) ? 16'h0000 : addr - base;
    end
endmodule

// File: rtl/mmd_bank_map.sv
// Module: switchable ROM bank number mapping.
// Promotes bank 0 to bank 1; any other value passes unchanged.
module mmd_bank_map #(
    parameter int W = 2
) (
    input  logic [W-1:0] bank_in,
    output logic [W-1:0] bank_eff
);
    // Bank 0 is never visible in the switchable window
    always_comb bank_eff = (bank_in == '0) ? W'(1) : bank_in;
endmodule

// File: rtl/mmd_store.sv
// Module: small byte store behind one region.
// Synchronous write, combinational read; contents are not reset.
module mmd_store #(
    parameter int IDX_W = 4,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata
);
    localparam int DEPTH = 1 << IDX_W;
    logic [DW-1:0] mem [DEPTH];

    // Store a byte on write
    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/mem_map_decoder.sv
// Module: banked memory address decoder top.
// Decodes the CPU address and forwards writes to the selected region's store.
// Returns registered read data, 0xFF for holes.
// Assumes the CPU never raises read and write in the same cycle.
module mem_map_decoder
    import mmd_pkg::*;
#(
    parameter int DW       = 8,
    parameter int STORE_AW = 4,
    parameter int ROMB_W   = 2,
    parameter int WRAMB_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [15:0]        cpu_addr,
    input  logic               cpu_rd,
    input  logic               cpu_wr,
    input  logic [DW-1:0]      cpu_wdata,
    input  logic [ROMB_W-1:0]  rom_bank,
    input  logic [WRAMB_W-1:0] wram_bank,
    output logic [NREG-1:0]    region_sel,
    output logic [15:0]        region_off,
    output logic               rd_valid,
    output logic [NREG-1:0]    rd_sel_q,
    output logic [DW-1:0]      rdata
);
    localparam int BANK_MAX = (ROMB_W > WRAMB_W) ? ROMB_W : WRAMB_W;
    localparam int MAXW     = STORE_AW + BANK_MAX;

    // Index width of each region's store
    function automatic int idx_w(input int r);
        if (r == RG_ROMX)  return STORE_AW + ROMB_W;
        if (r == RG_WRAMX) return STORE_AW + WRAMB_W;
        if (r == RG_IE)    return 1;
        return STORE_AW;
    endfunction

    logic [ROMB_W-1:0] rom_eff;
    logic [MAXW-1:0]   idx   [NREG];
    logic [DW-1:0]     rd_arr[NREG];
    logic [DW-1:0]     rd_mux;

    mmd_region_decode i_decode (
        .addr (cpu_addr),
        .sel  (region_sel),
        .off  (region_off)
    );

    mmd_bank_map #(.W(ROMB_W)) i_rom_bank (
        .bank_in  (rom_bank),
        .bank_eff (rom_eff)
    );

    // Build the store index of each region from offset and bank
    always_comb begin
        for (int r = 0; r < NREG; r++) begin
            if (r == RG_ROMX)
                idx[r] = MAXW'({rom_eff, region_off[STORE_AW-1:0]});
            else if (r == RG_WRAMX)
                idx[r] = MAXW'({wram_bank, region_off[STORE_AW-1:0]});
            else if (r == RG_IE)
                idx[r] = '0;
            else
                idx[r] = MAXW'(region_off[STORE_AW-1:0]);
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_store
        localparam int W = idx_w(g);
        mmd_store #(.IDX_W(W), .DW(DW)) i_store (
            .clk   (clk),
            .we    (cpu_wr && region_sel[g]),
            .idx   (idx[g][W-1:0]),
            .wdata (cpu_wdata),
            .rdata (rd_arr[g])
        );
    end

    // Select the addressed region's byte, all ones for a hole
    always_comb begin
        rd_mux = '0;
        for (int r = 0; r < NREG; r++) begin
            if (region_sel[r]) rd_mux = rd_arr[r];
        end
        if (region_sel == '0) rd_mux = {DW{1'b1}};
    end

    // Register read data and the captured select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= '0;
            rd_sel_q <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= cpu_rd;
            if (cpu_rd) begin
                rdata    <= rd_mux;
                rd_sel_q <= region_sel;
            end
        end
    end
endmodule

// File: rtl/mem_map_decoder_chk.sv
// Module: property checker for mem_map_decoder, attached by bind.
module mem_map_decoder_chk
    import mmd_pkg::*;
#(
    parameter int DW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [15:0]     cpu_addr,
    input logic            cpu_rd,
    input logic [NREG-1:0] region_sel,
    input logic [15:0]     region_off,
    input logic            rd_valid,
    input logic [NREG-1:0] rd_sel_q,
    input logic [DW-1:0]   rdata
);
    p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(region_sel));

    p_rom0_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'b00) |-> (region_sel == NREG'(1)));

    p_echo_hole_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr >= 16'hE000 && cpu_addr < 16'hFE00) |-> (region_sel == '0));

    p_romx_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        region_sel[RG_ROMX] |-> (region_off == cpu_addr - 16'h4000));

    p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rd |=> (rd_valid && rd_sel_q == $past(region_sel)));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd |=> (!rd_valid && $stable(rdata) && $stable(rd_sel_q)));

    p_hole_ff_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_sel_q == '0) |-> (rdata == {DW{1'b1}}));

    p_reset_r9: assert property (@(posedge clk)
        !rst_n |=> (rdata == '0 && rd_sel_q == '0 && !rd_valid));
endmodule

bind mem_map_decoder mem_map_decoder_chk #(.DW(DW)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_addr   (cpu_addr),
    .cpu_rd     (cpu_rd),
    .region_sel (region_sel),
    .region_off (region_off),
    .rd_valid   (rd_valid),
    .rd_sel_q   (rd_sel_q),
    .rdata      (rdata)
);

// File: tb/test_mem_map_decoder.sv
// Bench: full-address-space write and read sweeps against an arithmetic model.
module test_mem_map_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int NR  = 10;
    localparam int SAW = 4;
    localparam int RBW = 2;
    localparam int WBW = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [15:0]    cpu_addr = '0;
    logic           cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [7:0]     cpu_wdata = '0;
    logic [RBW-1:0] rom_bank = '0;
    logic [WBW-1:0] wram_bank = '0;
    logic [NR-1:0]  region_sel, rd_sel_q;
    logic [15:0]    region_off;
    logic           rd_valid;
    logic [7:0]     rdata;

    int  n_chk = 0, n_fail = 0;
    bit  done = 0;
    logic [7:0] mdl [NR*64];

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_map_decoder #(.DW(8), .STORE_AW(SAW), .ROMB_W(RBW), .WRAMB_W(WBW)) i_mem_map_decoder (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .rom_bank(rom_bank),
        .wram_bank(wram_bank), .region_sel(region_sel), .region_off(region_off),
        .rd_valid(rd_valid), .rd_sel_q(rd_sel_q), .rdata(rdata)
    );

    function automatic int exp_region(input int a);
        if (a < 'h4000) return 0;
        if (a < 'h8000) return 1;
        if (a < 'hA000) return 2;
        if (a < 'hC000) return 3;
        if (a < 'hD000) return 4;
        if (a < 'hE000) return 5;
        if (a >= 'hFE00 && a < 'hFEA0) return 6;
        if (a >= 'hFF00 && a < 'hFF80) return 7;
        if (a >= 'hFF80 && a < 'hFFFF) return 8;
        if (a == 'hFFFF) return 9;
        return -1;
    endfunction

    function automatic int exp_base(input int r);
        int b [NR] = '{'h0000, 'h4000, 'h8000, 'hA000, 'hC000, 'hD000,
                       'hFE00, 'hFF00, 'hFF80, 'hFFFF};
        return b[r];
    endfunction

    function automatic int mkey(input int a, input int rb, input int wb);
        int r, low;
        r = exp_region(a);
        low = (a - exp_base(r)) % (1 << SAW);
        if (r == 1) return r*64 + ((rb == 0) ? 1 : rb) * (1 << SAW) + low;
        if (r == 5) return r*64 + wb * (1 << SAW) + low;
        if (r == 9) return r*64;
        return r*64 + low;
    endfunction

    function automatic int exp_sel(input int a);
        int r = exp_region(a);
        return (r < 0) ? 0 : (1 << r);
    endfunction

    function automatic logic [7:0] exp_data(input int a, input int rb, input int wb);
        if (exp_region(a) < 0) return 8'hFF;
        return mdl[mkey(a, rb, wb)];
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input int a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a[15:0]; cpu_wdata = d; cpu_wr = 1'b1;
        if (exp_region(a) >= 0) mdl[mkey(a, int'(rom_bank), int'(wram_bank))] = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic do_read(input int a, output logic [7:0] v);
        @(negedge clk);
        cpu_addr = a[15:0]; cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
        v = rdata;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int prev;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        chk(rdata == 8'h00, "R9 rdata", rdata, 0);
        chk(!rd_valid && rd_sel_q == '0, "R9 valid/sel", int'(rd_sel_q), 0);
        rst_n = 1'b1;

        // Write sweep over the whole space, holes included (R5 model ignores them)
        rom_bank = 2'd1; wram_bank = 2'd1;
        for (int a = 0; a < 65536; a++) begin
            @(negedge clk);
            cpu_addr = a[15:0];
            cpu_wdata = a[7:0] ^ a[15:8] ^ 8'h5A;
            cpu_wr = 1'b1;
            if (exp_region(a) >= 0) mdl[mkey(a, 1, 1)] = cpu_wdata;
        end
        @(negedge clk);
        cpu_wr = 1'b0;

        // Pipelined read sweep: decode, offset, data and captured select
        prev = -1;
        for (int a = 0; a <= 65536; a++) begin
            @(negedge clk);
            if (prev >= 0) begin
                if (exp_region(prev) < 0)
                    chk(rdata == 8'hFF, "R4 hole read", rdata, 8'hFF);
                else
                    chk(rdata == exp_data(prev, 1, 1), "R10 stored data", rdata, exp_data(prev, 1, 1));
                chk(rd_valid && int'(rd_sel_q) == exp_sel(prev), "R6 captured select",
                    int'(rd_sel_q), exp_sel(prev));
            end
            if (a == 65536) begin
                cpu_rd = 1'b0;
            end else begin
                cpu_addr = a[15:0]; cpu_rd = 1'b1;
                #1;
                chk(int'(region_sel) == exp_sel(a), "R1 R3 select", int'(region_sel), exp_sel(a));
                chk(int'(region_off) == ((exp_region(a) < 0) ? 0 : a - exp_base(exp_region(a))),
                    "R2 offset", int'(region_off),
                    (exp_region(a) < 0) ? 0 : a - exp_base(exp_region(a)));
                prev = a;
            end
        end
        // R6: idle cycles hold data and drop valid
        @(negedge clk);
        chk(!rd_valid && rdata == exp_data(65535, 1, 1), "R6 idle hold", rdata, exp_data(65535, 1, 1));

        // R7 / R8: bank switching
        for (int b = 0; b < 4; b++) begin
            rom_bank = b[RBW-1:0]; wram_bank = b[WBW-1:0];
            do_write('h4003, 8'hA0 + b[7:0]);
            do_write('hD003, 8'hC0 + b[7:0]);
        end
        for (int b = 0; b < 4; b++) begin
            rom_bank = b[RBW-1:0]; wram_bank = b[WBW-1:0];
            do_read('h4003, v);
            chk(v == exp_data('h4003, b, b), "R7 rom bank", v, exp_data('h4003, b, b));
            do_read('hD003, v);
            chk(v == (8'hC0 + b[7:0]), "R8 wram bank", v, 8'hC0 + b);
        end
        rom_bank = 2'd0;
        do_read('h4003, v);
        chk(v == 8'hA1, "R7 bank0 as bank1", v, 8'hA1);

        // R5: hole writes leave stores alone
        do_write('hC005, 8'h11);
        do_write('hE005, 8'h99);
        do_write('hFEA5, 8'h77);
        do_read('hC005, v);
        chk(v == 8'h11, "R5 after hole write", v, 8'h11);
        do_read('hE005, v);
        chk(v == 8'hFF, "R5 R4 hole stays FF", v, 8'hFF);
        // R10: mirroring onto a 16-byte store
        do_write('h8123, 8'h3C);
        do_read('h8003, v);
        chk(v == 8'h3C, "R10 mirror", v, 8'h3C);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule